// File: doc/BRIEF.md
# Timer Gate Control

This block decides, cycle by cycle, whether a 16-bit timer counter may advance on its count tick. An external gate pin is first synchronized, then passed through a selectable polarity inversion. An optional toggle flip-flop turns each rising edge of that signal into an alternating level. An optional one-shot stage arms on software request, opens on the next rising edge of the processed gate, and closes when that gate falls.

Software controls the block through a single control byte. Five control bits are writable: enable, polarity, toggle, one-shot and arm/done. One read-only bit shows the live processed gate level. The counter can be loaded one byte at a time. It wraps silently from its maximum value to zero.

Top module: `tmr_gate_ctl`

## Requirements
- R1: After reset the control byte reads 0x04 with the gate pin held low, and the count reads 0.
- R2: Control byte layout: bit 7 gate enable, bit 6 polarity, bit 5 toggle mode, bit 4 one-shot mode, bit 3 arm/done, bit 2 live gate (read-only), bits 1:0 read 0. Writes to bits 2:0 have no effect.
- R3: The pin reaches the live gate bit two clock edges after it changes. With polarity 1 the live bit equals the synchronized pin; with polarity 0 it is the inverse.
- R4: With gate enable 0, the count increments on every tick, whatever the gate is.
- R5: With gate enable 1 and one-shot mode 0, the count increments on a tick only while the live gate bit is 1.
- R6: With toggle mode 1, the live gate bit is a flip-flop that inverts on each rising edge of the polarity-adjusted synchronized pin. While toggle mode is 0 that flip-flop is held at 0, so switching toggle mode on starts it at 0.
- R7: With one-shot mode 1, arm/done 1 and gate enable 1, counting is blocked until the live gate rises. It then continues while the gate stays high. When the gate falls, hardware clears arm/done and counting stays blocked.
- R8: Arm/done can only be 1 while one-shot mode is 1. Writing one-shot mode 0 clears it, and writing arm/done 1 together with one-shot mode 0 leaves it 0.
- R9: The live gate bit is independent of gate enable.
- R10: Writing the low or high count byte loads that byte and suppresses the increment in that cycle. An increment from 0xFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count tick qualifier |
| gate_in | input | 1 | Raw external gate pin |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| cnt_lo_we | input | 1 | Low count byte write strobe |
| cnt_lo_wdata | input | 8 | Low count byte data |
| cnt_hi_we | input | 1 | High count byte write strobe |
| cnt_hi_wdata | input | 8 | High count byte data |
| count | output | 16 | Current count value |
| gate_live | output | 1 | Live processed gate level |

## Verification
A toggle flip-flop in the wrong state shows on the live gate bit from the cycle after the edge that set it. It stays wrong until the next rising edge or a toggle-mode clear. A stale one-shot or arm/done state shows as a read of bit 3 and as counts added after the pulse closed, on the first tick following the falling gate. The bench's reference model compares count, live bit and control byte on every clock, so a divergence is reported within one cycle of reaching a port.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int unsigned BIT_GE   = 7;
  localparam int unsigned BIT_POL  = 6;
  localparam int unsigned BIT_TM   = 5;
  localparam int unsigned BIT_SPM  = 4;
  localparam int unsigned BIT_GO   = 3;
  localparam int unsigned BIT_LIVE = 2;

  typedef struct packed {
    logic ge;
    logic pol;
    logic tm;
    logic spm;
    logic go;
  } tgc_ctrl_t;

  function automatic logic apply_pol(input logic g, input logic pol);
    return pol ? g : ~g;
  endfunction

  function automatic logic [7:0] pack_status(input tgc_ctrl_t c, input logic live);
    logic [7:0] r;
    r = '0;
    r[BIT_GE]   = c.ge;
    r[BIT_POL]  = c.pol;
    r[BIT_TM]   = c.tm;
    r[BIT_SPM]  = c.spm;
    r[BIT_GO]   = c.go;
    r[BIT_LIVE] = live;
    return r;
  endfunction
endpackage

// File: rtl/tgc_gate_front.sv
module tgc_gate_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  input  logic pol,
  input  logic tm,
  output logic pol_rise,
  output logic tff_q,
  output logic gv,
  output logic gv_rise,
  output logic gv_fall
);
  import tgc_pkg::*;
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pg, pg_q, gv_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= gate_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  assign pg       = apply_pol(sync_q[LAST], pol);
  assign pol_rise = pg & ~pg_q;
  assign gv       = tm ? tff_q : pg;
  assign gv_rise  = gv & ~gv_q;
  assign gv_fall  = ~gv & gv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      gv_q  <= 1'b0;
      tff_q <= 1'b0;
    end else begin
      pg_q <= pg;
      gv_q <= gv;
      if (!tm)           tff_q <= 1'b0;
      else if (pol_rise) tff_q <= ~tff_q;
    end
  end
endmodule

// File: rtl/tgc_ctrl_reg.sv
module tgc_ctrl_reg (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [7:3]          wfield,
  input  logic                done_evt,
  output tgc_pkg::tgc_ctrl_t  ctrl
);
  import tgc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (reg_wr) begin
      ctrl.ge  <= wfield[BIT_GE];
      ctrl.pol <= wfield[BIT_POL];
      ctrl.tm  <= wfield[BIT_TM];
      ctrl.spm <= wfield[BIT_SPM];
      ctrl.go  <= wfield[BIT_GO] & wfield[BIT_SPM];
    end else if (!ctrl.spm || done_evt) begin
      ctrl.go <= 1'b0;
    end
  end
endmodule

// File: rtl/tgc_pulse_ctl.sv
module tgc_pulse_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_wr,
  input  logic spm,
  input  logic go,
  input  logic gv_rise,
  input  logic gv_fall,
  output logic in_pulse_q,
  output logic pulse_open,
  output logic done_evt
);
  assign pulse_open = in_pulse_q | (go & gv_rise);
  assign done_evt   = in_pulse_q & gv_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          in_pulse_q <= 1'b0;
    else if (reg_wr || !spm || done_evt) in_pulse_q <= 1'b0;
    else if (go && gv_rise)              in_pulse_q <= 1'b1;
  end
endmodule

// File: rtl/tgc_counter.sv
module tgc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc,
  input  logic               lo_we,
  input  logic [7:0]         lo_wdata,
  input  logic               hi_we,
  input  logic [CNT_W-9:0]   hi_wdata,
  output logic [CNT_W-1:0]   count
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (lo_we || hi_we) begin
      if (lo_we) count[7:0]       <= lo_wdata;
      if (hi_we) count[CNT_W-1:8] <= hi_wdata;
    end else if (inc) begin
      count <= bump(count);
    end
  end
endmodule

// File: rtl/tmr_gate_ctl.sv
module tmr_gate_ctl #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             gate_in,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             cnt_lo_we,
  input  logic [7:0]       cnt_lo_wdata,
  input  logic             cnt_hi_we,
  input  logic [CNT_W-9:0] cnt_hi_wdata,
  output logic [CNT_W-1:0] count,
  output logic             gate_live
);
  import tgc_pkg::*;

  tgc_ctrl_t ctrl;
  logic pol_rise, tff_q, gv, gv_rise, gv_fall;
  logic in_pulse_q, pulse_open, done_evt;
  logic cnt_en, cnt_inc, cnt_wr;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[2:0];

  tgc_gate_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .pol(ctrl.pol), .tm(ctrl.tm),
    .pol_rise(pol_rise), .tff_q(tff_q), .gv(gv), .gv_rise(gv_rise), .gv_fall(gv_fall)
  );

  tgc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wfield(reg_wdata[7:3]),
    .done_evt(done_evt), .ctrl(ctrl)
  );

  tgc_pulse_ctl u_pulse (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .spm(ctrl.spm), .go(ctrl.go),
    .gv_rise(gv_rise), .gv_fall(gv_fall), .in_pulse_q(in_pulse_q),
    .pulse_open(pulse_open), .done_evt(done_evt)
  );

  assign cnt_en  = ~ctrl.ge | (gv & (~ctrl.spm | pulse_open));
  assign cnt_inc = tick & cnt_en;
  assign cnt_wr  = cnt_lo_we | cnt_hi_we;

  tgc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc),
    .lo_we(cnt_lo_we), .lo_wdata(cnt_lo_wdata),
    .hi_we(cnt_hi_we), .hi_wdata(cnt_hi_wdata), .count(count)
  );

  assign reg_rdata = pack_status(ctrl, gv);
  assign gate_live = gv;
endmodule

// File: rtl/tmr_gate_ctl_chk.sv
module tmr_gate_ctl_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ge,
  input logic             spm,
  input logic             go,
  input logic             tm,
  input logic             tff_q,
  input logic             gv,
  input logic             gv_fall,
  input logic             in_pulse_q,
  input logic             reg_wr,
  input logic             cnt_wr,
  input logic             cnt_inc,
  input logic [CNT_W-1:0] count
);
  assert_go_needs_spm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> spm);

  assert_tff_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tm |=> !tff_q);

  assert_free_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ge && tick && !cnt_wr) |=> count == CNT_W'($past(count) + 1'b1));

  assert_hold_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ge && !spm && !gv && !cnt_wr) |=> $stable(count));

  assert_pulse_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pulse_q && gv_fall && !reg_wr) |=> !go);

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && !cnt_wr && count == {CNT_W{1'b1}}) |=> count == '0);
endmodule

bind tmr_gate_ctl tmr_gate_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ge(ctrl.ge), .spm(ctrl.spm),
  .go(ctrl.go), .tm(ctrl.tm), .tff_q(tff_q), .gv(gv), .gv_fall(gv_fall),
  .in_pulse_q(in_pulse_q), .reg_wr(reg_wr), .cnt_wr(cnt_wr),
  .cnt_inc(cnt_inc), .count(count)
);

// File: tb/tmr_gate_ctl_bench.sv
`timescale 1ns/1ps
module tmr_gate_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate_in = 1'b0;
  logic reg_wr = 1'b0, cnt_lo_we = 1'b0, cnt_hi_we = 1'b0;
  logic [7:0] reg_wdata = '0, cnt_lo_wdata = '0, cnt_hi_wdata = '0;
  logic [7:0] reg_rdata;
  logic [15:0] count;
  logic gate_live;
  int n_checks = 0, n_errors = 0;

  always #2 clk = ~clk;

  tmr_gate_ctl u_tmr_gate_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_in(gate_in),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_lo_we(cnt_lo_we), .cnt_lo_wdata(cnt_lo_wdata),
    .cnt_hi_we(cnt_hi_we), .cnt_hi_wdata(cnt_hi_wdata),
    .count(count), .gate_live(gate_live)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_sync[$];
  bit m_pgq, m_gvq, m_tff, m_inp;
  bit m_ge, m_pol, m_tm, m_spm, m_go;
  int m_cnt;

  function automatic bit m_pg();
    return m_pol ? m_sync[0] : !m_sync[0];
  endfunction
  function automatic bit m_gv();
    return m_tm ? m_tff : m_pg();
  endfunction
  function automatic int m_rd();
    return (m_ge << 7) | (m_pol << 6) | (m_tm << 5) | (m_spm << 4) |
           (m_go << 3) | (m_gv() << 2);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = {1'b0, 1'b0};
      {m_pgq, m_gvq, m_tff, m_inp, m_ge, m_pol, m_tm, m_spm, m_go} = '0;
      m_cnt = 0;
    end else begin
      bit pg, prise, gv, grise, gfall, en, done;
      pg = m_pg();
      prise = pg && !m_pgq;
      gv = m_gv();
      grise = gv && !m_gvq;
      gfall = !gv && m_gvq;
      en = !m_ge || (gv && (!m_spm || m_inp || (m_go && grise)));
      done = m_inp && gfall;
      if (cnt_lo_we || cnt_hi_we) begin
        if (cnt_lo_we) m_cnt = (m_cnt & 'hFF00) | int'(cnt_lo_wdata);
        if (cnt_hi_we) m_cnt = (m_cnt & 'h00FF) | (int'(cnt_hi_wdata) << 8);
      end else if (tick && en) begin
        m_cnt = (m_cnt + 1) % 65536;
      end
      if (!m_tm) m_tff = 0;
      else if (prise) m_tff = !m_tff;
      if (reg_wr || !m_spm || done) m_inp = 0;
      else if (m_go && grise) m_inp = 1;
      if (reg_wr) begin
        {m_ge, m_pol, m_tm, m_spm} = reg_wdata[7:4];
        m_go = reg_wdata[3] && reg_wdata[4];
      end else begin
        m_go = m_spm && m_go && !done;
      end
      m_pgq = pg;
      m_gvq = gv;
      m_sync.push_back(gate_in);
      void'(m_sync.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R4/R5/R7/R10 count vs model", count, m_cnt);
      check("R3/R6/R9 live vs model", gate_live, m_gv());
      check("R2/R8 control byte vs model", reg_rdata, m_rd());
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic set_cnt(input logic [15:0] v);
    cnt_lo_we = 1'b1; cnt_hi_we = 1'b1;
    cnt_lo_wdata = v[7:0]; cnt_hi_wdata = v[15:8];
    @(negedge clk);
    cnt_lo_we = 1'b0; cnt_hi_we = 1'b0;
  endtask
  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    check("R1 reset control byte", reg_rdata, 8'h04);
    check("R1 reset count", count, 0);

    wr_ctrl(8'h47);
    check("R2 low bits ignored", reg_rdata, 8'h40);

    gate_in = 1'b1;
    wait_clk(1);
    check("R3 sync one edge", gate_live, 0);
    wait_clk(1);
    check("R3 sync two edges", gate_live, 1);
    wr_ctrl(8'h00);
    check("R3 active-low inverts", reg_rdata, 8'h00);

    wr_ctrl(8'h40);
    check("R9 live with enable off", reg_rdata, 8'h44);
    wr_ctrl(8'hC0);
    check("R9 live with enable on", reg_rdata, 8'hC4);

    tick = 1'b1;
    gate_in = 1'b0;
    wait_clk(3);
    set_cnt(16'h0100);
    wait_clk(5);
    check("R5 gate closed holds", count, 16'h0100);
    gate_in = 1'b1;
    wait_clk(6);
    check("R5 gate open counts", count, 16'h0104);

    wr_ctrl(8'h40);
    set_cnt(16'h0000);
    gate_in = 1'b0;
    wait_clk(10);
    check("R4 free run", count, 10);

    set_cnt(16'hFFFE);
    wait_clk(2);
    check("R10 wrap", count, 0);
    cnt_lo_we = 1'b1; cnt_lo_wdata = 8'h12;
    wait_clk(3);
    cnt_lo_we = 1'b0;
    check("R10 low write overrides tick", count, 16'h0012);
    cnt_hi_we = 1'b1; cnt_hi_wdata = 8'hAB;
    wait_clk(1);
    cnt_hi_we = 1'b0;
    check("R10 high byte write", count, 16'hAB12);

    wr_ctrl(8'hE0);
    wait_clk(3);
    check("R6 toggle starts low", gate_live, 0);
    gate_in = 1'b1; wait_clk(3); gate_in = 1'b0; wait_clk(4);
    check("R6 first rise sets", gate_live, 1);
    gate_in = 1'b1; wait_clk(3); gate_in = 1'b0; wait_clk(4);
    check("R6 second rise clears", gate_live, 0);
    wr_ctrl(8'hC0);
    gate_in = 1'b1; wait_clk(3); gate_in = 1'b0; wait_clk(4);
    wr_ctrl(8'hE0);
    check("R6 held clear while off", gate_live, 0);

    wr_ctrl(8'hD8);
    set_cnt(16'h0000);
    wait_clk(4);
    check("R7 armed and blocked", count, 0);
    check("R7 armed flag", reg_rdata[3], 1);
    gate_in = 1'b1; wait_clk(5); gate_in = 1'b0; wait_clk(6);
    check("R7 one interval counted", count, 5);
    check("R7 done cleared", reg_rdata[3], 0);
    gate_in = 1'b1; wait_clk(5); gate_in = 1'b0; wait_clk(6);
    check("R7 second pulse ignored", count, 5);

    wr_ctrl(8'h98);
    check("R8 armed", reg_rdata[3], 1);
    wr_ctrl(8'h88);
    check("R8 cleared with mode off", reg_rdata[3], 0);

    wait_clk(2);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule